// File: doc/BRIEF.md
# PWM Channel Clock Selection Unit

This unit feeds every channel of an eight-channel pulse-width modulator with a clock-enable strobe, all derived from the single bus clock. A shared free-running counter produces two prescaled strobes, A and B, whose rates are set by two independent 3-bit fields. Each of them also drives a reload divider that produces a slower strobe, SA from A and SB from B, at a ratio set by an 8-bit scale register.

Every channel owns two select bits: a "scaled" bit that picks the divided strobe, and a "swap" bit that exchanges the A and B families. Channels whose index modulo 4 is 2 or 3 use a mirrored mapping, so with all bits cleared half the channels run from A and half from B. A small register port writes and reads back the select, prescale and scale registers. Counters, duty comparators and pins of the modulator lie outside the unit; it only hands out single-cycle enable pulses, one per channel.

Top module: `pwm_clk_sel_top`

## Requirements
- R1: For a channel whose index modulo 4 is 0 or 1, the pair {swap bit, scaled bit} selects 00 = A, 01 = SA, 10 = B, 11 = SB. The scaled bit of channel i is bit i of the register at address 0; the swap bit is bit i of the register at address 1.
- R2: For a channel whose index modulo 4 is 2 or 3, the same pair selects 00 = B, 01 = SB, 10 = A, 11 = SA.
- R3: The prescale register sits at address 2 with the A field in bits 2:0 and the B field in bits 6:4; bits 7 and 3 ignore writes and always read zero.
- R4: A prescale field value N makes its strobe pulse once every 2^N bus cycles, for N from 0 to 7.
- R5: SA pulses once every 2·M pulses of A, where M is the register at address 3 and M = 0 stands for 256; SB is built the same way from B with M at address 4.
- R6: After reset every register reads zero, no enable is asserted, and channels in the first group run from A while those in the second run from B.
- R7: A prescale write takes effect on the very next cycle, without waiting for or restarting the counter.
- R8: With the channel count parameter below eight, writes to select bits of absent channels are dropped and those bits read zero.
- R9: Each channel enable is one bus cycle wide and follows a pulse of its selected source by exactly one cycle; it never pulses without such a source pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr (combinational) |
| ch_en | output | NCH | Per-channel single-cycle clock enables |

## Verification
On every cycle the assertions check that enables only follow a source pulse, that the divided strobes coincide with their parent strobes, that the A strobe reaches the channels that route it, that a zero prescale pulses continuously, and that reserved and absent-channel bits read zero. The bench scenarios are needed for the rates themselves: the spacing for all eight prescale values, the 2·M ratio including the 256 wrap, every select combination in both groups, the reset routing, and the immediate effect of a prescale rewrite, all measured at the enable outputs.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;
  localparam int PSC_W  = 3;
  localparam int SCL_W  = 8;

  localparam logic [REG_AW-1:0] ADDR_SCALED = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_SWAP   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_PSC    = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_SCL_A  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_SCL_B  = 3'd4;

  // field positions inside the prescale register
  localparam int PSC_A_LSB = 0;
  localparam int PSC_B_LSB = 4;
endpackage

// File: rtl/pwm_clk_regs.sv
module pwm_clk_regs
  import pwm_clk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [REG_DW-1:0]    wdata,
  output logic [REG_DW-1:0]    rdata,
  output logic [NCH-1:0]       scaled_sel,
  output logic [NCH-1:0]       swap_sel,
  output logic [PSC_W-1:0]     psc_a,
  output logic [PSC_W-1:0]     psc_b,
  output logic [SCL_W-1:0]     scl_a,
  output logic [SCL_W-1:0]     scl_b
);
  localparam logic [REG_DW-1:0] CH_MASK = REG_DW'((1 << NCH) - 1);

  logic [NCH-1:0]   scaled_q, scaled_d;
  logic [NCH-1:0]   swap_q, swap_d;
  logic [PSC_W-1:0] psc_a_q, psc_a_d, psc_b_q, psc_b_d;
  logic [SCL_W-1:0] scl_a_q, scl_a_d, scl_b_q, scl_b_d;

  always_comb begin
    scaled_d = scaled_q;
    swap_d   = swap_q;
    psc_a_d  = psc_a_q;
    psc_b_d  = psc_b_q;
    scl_a_d  = scl_a_q;
    scl_b_d  = scl_b_q;
    if (wr_en) begin
      case (addr)
        ADDR_SCALED: scaled_d = wdata[NCH-1:0];
        ADDR_SWAP:   swap_d   = wdata[NCH-1:0];
        ADDR_PSC: begin
          psc_a_d = wdata[PSC_A_LSB +: PSC_W];
          psc_b_d = wdata[PSC_B_LSB +: PSC_W];
        end
        ADDR_SCL_A:  scl_a_d = wdata[SCL_W-1:0];
        ADDR_SCL_B:  scl_b_d = wdata[SCL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaled_q <= '0;
      swap_q   <= '0;
      psc_a_q  <= '0;
      psc_b_q  <= '0;
      scl_a_q  <= '0;
      scl_b_q  <= '0;
    end else begin
      scaled_q <= scaled_d;
      swap_q   <= swap_d;
      psc_a_q  <= psc_a_d;
      psc_b_q  <= psc_b_d;
      scl_a_q  <= scl_a_d;
      scl_b_q  <= scl_b_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_SCALED: rdata[NCH-1:0] = scaled_q;
      ADDR_SWAP:   rdata[NCH-1:0] = swap_q;
      ADDR_PSC: begin
        rdata[PSC_A_LSB +: PSC_W] = psc_a_q;
        rdata[PSC_B_LSB +: PSC_W] = psc_b_q;
      end
      ADDR_SCL_A:  rdata[SCL_W-1:0] = scl_a_q;
      ADDR_SCL_B:  rdata[SCL_W-1:0] = scl_b_q;
      default: ;
    endcase
  end

  assign scaled_sel = scaled_q;
  assign swap_sel   = swap_q;
  assign psc_a      = psc_a_q;
  assign psc_b      = psc_b_q;
  assign scl_a      = scl_a_q;
  assign scl_b      = scl_b_q;

  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_PSC) |-> (rdata[7] == 1'b0 && rdata[3] == 1'b0));

  // R8
  absent_ch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_SCALED || addr == ADDR_SWAP) |-> ((rdata & ~CH_MASK) == '0));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_a,
  input  logic [PSC_W-1:0] psc_b,
  output logic             tick_a,
  output logic             tick_b
);
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask_a, mask_b;

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    // wrap of the shift at N = 7 still yields the all-ones mask
    mask_a = (CNT_W'(1) << psc_a) - CNT_W'(1);
    mask_b = (CNT_W'(1) << psc_b) - CNT_W'(1);
    tick_a = (cnt_q & mask_a) == mask_a;
    tick_b = (cnt_q & mask_b) == mask_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  psc_zero_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_a == '0) |-> tick_a);

  // R4
  no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_b && psc_b != '0) |=> (!tick_b || psc_b != $past(psc_b)));
endmodule

// File: rtl/pwm_scaled_div.sv
module pwm_scaled_div
  import pwm_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [SCL_W-1:0] scale,
  output logic             s_tick
);
  localparam int DIV_W = SCL_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last_idx;
  logic             wrap;

  always_comb begin
    if (scale == '0) last_idx = {DIV_W{1'b1}};
    else             last_idx = {scale, 1'b0} - DIV_W'(1);
    // >= lets a shrunk scale recover at once instead of running to overflow
    wrap   = cnt_q >= last_idx;
    s_tick = src_tick && wrap;
    cnt_d  = cnt_q;
    if (src_tick) cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  scaled_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_tick |-> src_tick);
endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_a,
  input  logic           tick_b,
  input  logic           tick_sa,
  input  logic           tick_sb,
  input  logic [NCH-1:0] scaled_sel,
  input  logic [NCH-1:0] swap_sel,
  output logic [NCH-1:0] ch_en
);
  logic [NCH-1:0] en_d, en_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit GRP_HI = (i % 4) >= 2;
    logic use_b;

    always_comb begin
      use_b = swap_sel[i] ^ GRP_HI;
      case ({use_b, scaled_sel[i]})
        2'b00:   en_d[i] = tick_a;
        2'b01:   en_d[i] = tick_sa;
        2'b10:   en_d[i] = tick_b;
        default: en_d[i] = tick_sb;
      endcase
    end

    // R9
    en_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |-> $past(tick_a || tick_b || tick_sa || tick_sb));

    // R1, R2
    a_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scaled_sel[i] && (swap_sel[i] == GRP_HI) && tick_a) |=> en_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign ch_en = en_q;
endmodule

// File: rtl/pwm_clk_sel_top.sv
module pwm_clk_sel_top
  import pwm_clk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic [NCH-1:0]    ch_en
);
  logic [NCH-1:0]   scaled_sel, swap_sel;
  logic [PSC_W-1:0] psc_a, psc_b;
  logic [SCL_W-1:0] scl_a, scl_b;
  logic             tick_a, tick_b, tick_sa, tick_sb;

  pwm_clk_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .scaled_sel(scaled_sel), .swap_sel(swap_sel),
    .psc_a(psc_a), .psc_b(psc_b), .scl_a(scl_a), .scl_b(scl_b)
  );

  pwm_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .psc_a(psc_a), .psc_b(psc_b),
    .tick_a(tick_a), .tick_b(tick_b)
  );

  pwm_scaled_div u_div_a (
    .clk(clk), .rst_n(rst_n), .src_tick(tick_a), .scale(scl_a), .s_tick(tick_sa)
  );

  pwm_scaled_div u_div_b (
    .clk(clk), .rst_n(rst_n), .src_tick(tick_b), .scale(scl_b), .s_tick(tick_sb)
  );

  pwm_chan_sel #(.NCH(NCH)) u_sel (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .tick_sa(tick_sa), .tick_sb(tick_sb), .scaled_sel(scaled_sel),
    .swap_sel(swap_sel), .ch_en(ch_en)
  );
endmodule

// File: tb/tb_pwm_clk_sel_top.sv
module tb_pwm_clk_sel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata6;
  logic [7:0] ch_en;
  logic [5:0] ch_en6;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_clk_sel_top #(.NCH(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_en(ch_en)
  );

  pwm_clk_sel_top #(.NCH(6)) dut6 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata6), .ch_en(ch_en6)
  );

  // scoreboard: expected pulse spacings and their requirement tags
  int    exp_q[$];
  string tag_q[$];
  int    mon_ch = 0;
  bit    mon_arm = 0;
  int    cyc = 0;
  int    last_t = -1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!mon_arm) last_t = -1;
    else if (ch_en[mon_ch]) begin
      if (last_t >= 0 && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, cyc - last_t, e);
      end
      last_t = cyc;
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp, bit six);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, six ? int'(rdata6) : int'(rdata), int'(exp));
  endtask

  task automatic measure(string req, int ch, int exp, int n);
    int guard;
    @(posedge clk);
    mon_ch = ch;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    mon_arm = 1;
    guard = 0;
    while (exp_q.size() > 0 && guard < (n + 2) * exp + 20) begin
      @(posedge clk);
      guard++;
    end
    mon_arm = 0;
    if (exp_q.size() > 0) begin
      chk({req, " missing pulses"}, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  initial begin
    int g0[4];
    int g1[4];
    int chs[4];
    g0 = '{1, 4, 2, 12};   // index {swap,scaled}: A, SA, B, SB
    g1 = '{2, 12, 1, 4};   // B, SB, A, SA
    chs = '{0, 2, 5, 7};

    repeat (3) @(negedge clk);
    chk("R6 enables in reset", int'(ch_en), 0);
    rst_n = 1'b1;

    // R6 reset values and default routing
    for (int a = 0; a < 5; a++) rd_chk("R6 reset register", 3'(a), 8'h00, 0);
    measure("R6 ch0 default", 0, 1, 2);
    wr(3'd2, 8'h10);   // B = /2, A = /1, selects untouched
    measure("R6 ch0 from A", 0, 1, 2);
    measure("R6 ch2 from B", 2, 2, 2);

    // R3 reserved bits
    wr(3'd2, 8'hFF);
    rd_chk("R3 prescale readback", 3'd2, 8'h77, 0);
    wr(3'd2, 8'h88);
    rd_chk("R3 reserved ignored", 3'd2, 8'h00, 0);

    // R4 sweep all prescale values on both strobes
    for (int n = 0; n < 8; n++) begin
      wr(3'd2, 8'(((7 - n) << 4) | n));
      measure("R4 clock A spacing", 0, 1 << n, 2);
      measure("R4 clock B spacing", 3, 1 << (7 - n), 2);
    end

    // R9 single-cycle width
    wr(3'd2, 8'h02);
    begin
      int guard = 0;
      @(negedge clk);
      while (!ch_en[0] && guard < 20) begin @(negedge clk); guard++; end
      chk("R9 pulse seen", int'(ch_en[0]), 1);
      @(negedge clk);
      chk("R9 pulse width one cycle", int'(ch_en[0]), 0);
    end

    // R7 immediate prescale effect
    wr(3'd2, 8'h07);
    repeat (5) @(negedge clk);
    wr(3'd2, 8'h00);
    @(negedge clk);
    chk("R7 pulse one cycle after write", int'(ch_en[0]), 1);
    @(negedge clk);
    chk("R7 continuous after write", int'(ch_en[0]), 1);

    // R1 R2 mapping sweep: A=1, B=2, SA=4, SB=12
    wr(3'd2, 8'h10);
    wr(3'd3, 8'd2);
    wr(3'd4, 8'd3);
    rd_chk("R5 scale A readback", 3'd3, 8'd2, 0);
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, (s & 1) ? 8'hFF : 8'h00);
      wr(3'd1, (s & 2) ? 8'hFF : 8'h00);
      foreach (chs[j]) begin
        if ((chs[j] % 4) >= 2) measure("R2 group-hi mapping", chs[j], g1[s], 2);
        else                   measure("R1 group-lo mapping", chs[j], g0[s], 2);
      end
    end

    // R5 scale value 0 means 256
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    measure("R5 SA with M=0", 0, 512, 2);

    // R8 absent channels on the 6-channel instance
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    rd_chk("R8 scaled bits absent", 3'd0, 8'h3F, 1);
    rd_chk("R8 swap bits absent", 3'd1, 8'h3F, 1);
    rd_chk("R8 full instance keeps all", 3'd0, 8'hFF, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule